// File: doc/BRIEF.md
# Banked CAM-Tag Read Cache

This block is a unified 4 KB cache that sits between a processor request port and a word-wide memory port. Its tags are kept in four content-addressable banks of 64 entries. Two address bits choose one bank per access, and only that bank compares its 64 stored tags against the incoming tag. The other banks stay quiet. A match gives the entry index, and the bank number, entry index and word offset together address a 1024-word data RAM. A read hit returns the word in the same cycle as the request.

On a read miss the block picks a victim entry in the chosen bank. It takes the lowest-numbered free entry if the bank has one. Otherwise it takes the value of a free-running 6-bit pseudo-random generator. It then fetches the four words of the line from memory in ascending order and returns the requested word once the line is complete. The processor port stalls for the whole fill.

Every write is sent to memory (write-through). A write that hits also updates the cached word in the cycle the memory accepts the write. A write that misses leaves the cache unchanged. A flush input and the reset both invalidate every entry.

Top module: `cam_cache`

## Requirements
- R1: The 28-bit byte address is split as byte offset [1:0] (ignored by lookup), word in line [3:2], bank select [5:4] and a 22-bit tag [27:6]. Addresses that differ only in bits [1:0] return the same word.
- R2: A read that hits raises cpu_ack in the same cycle as cpu_req, with the cached word on cpu_rdata, and makes no memory access.
- R3: The tag is compared only in the bank named by address bits [5:4]. The same tag in two different banks occupies two separate lines, and at most one bank reports a match in any cycle.
- R4: A read miss issues exactly four memory reads (mem_we=0) at {tag, bank, word, 2'b00} for word = 0, 1, 2, 3 in that order.
- R5: After a fill, cpu_ack rises for one cycle, the cycle after the fourth mem_ack, carrying the requested word. Later reads to the line hit, and a tag is never present twice in one bank.
- R6: While mem_req is high and mem_ack is low, mem_req, mem_we and mem_addr stay unchanged in the next cycle. cpu_ack stays low while a line fill is in progress.
- R7: The victim is the lowest-numbered invalid entry of the selected bank. When all 64 entries of the bank are valid, the victim comes from a 6-bit maximal-length LFSR that changes value every clock and never holds zero. A bank therefore keeps 64 distinct lines before any eviction happens.
- R8: Every write drives one memory write with mem_we=1, mem_addr equal to cpu_addr and mem_wdata equal to cpu_wdata, and cpu_ack rises in the cycle of mem_ack. A write hit updates the cached word. A write miss makes no memory read and allocates nothing.
- R9: A flush pulse invalidates every entry. If flush coincides with the last word of a fill, that line also ends up invalid.
- R10: During and right after reset, cpu_ack and mem_req are low and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| cpu_req | input | 1 | Processor request, held until cpu_ack |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 28 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack on reads |
| cpu_ack | output | 1 | Request complete |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 28 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory accepts or returns a word |

## Verification
Two pairs of events can land in the same cycle. In the first, a write hit updates the data RAM in the cycle its memory write is acknowledged. The bench provokes this by writing to a resident word and then reading it back: the read must hit and return the new value, with no fill. In the second, a flush arrives on the cycle of the final fill acknowledge. The bench raises flush exactly when the fourth mem_ack is visible, checks that the requested word is still returned, and then requires the next read of that line to cause a fresh four-word fill.

// File: rtl/cam_cache_pkg.sv
// Package: shared state type and helpers for the banked CAM-tag cache.
// Assumes: LFSR widths between 2 and 10 bits.
package cam_cache_pkg;

    typedef enum logic [1:0] {
        CC_IDLE,
        CC_WRITE,
        CC_FILL,
        CC_RESP
    } cc_state_t;

    // Feedback mask of a maximal-length Fibonacci LFSR shifting left
    function automatic logic [15:0] lfsr_taps(input int w);
        case (w)
            2:       return 16'h0003;
            3:       return 16'h0006;
            4:       return 16'h000C;
            5:       return 16'h0014;
            6:       return 16'h0030;
            7:       return 16'h0060;
            8:       return 16'h00B8;
            9:       return 16'h0110;
            10:      return 16'h0240;
            default: return 16'h0030;
        endcase
    endfunction

endpackage

// File: rtl/cc_lfsr.sv
// Free-running maximal-length LFSR used as the replacement picker.
// Assumes: W is between 2 and 10. The seed is 1, and a maximal-length
// sequence never enters the all-zero state.
module cc_lfsr #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state_q
);
    localparam logic [W-1:0] MASK = W'(cam_cache_pkg::lfsr_taps(W));

    // Advance one step every clock
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= W'(1);
        else        state_q <= {state_q[W-2:0], ^(state_q & MASK)};
    end
endmodule

// File: rtl/cc_tag_bank.sv
// One content-addressable tag bank: ENTRIES tags with valid bits.
// Compares all entries in parallel only when search_en is high. It
// reports the matching index and the lowest invalid entry.
// Assumes: at most one entry matches (the owner never allocates a present tag).
module cc_tag_bank #(
    parameter int TAG_W   = 22,
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               search_en,
    input  logic [TAG_W-1:0]   search_tag,
    input  logic               alloc,
    input  logic [IDX_W-1:0]   alloc_idx,
    input  logic               commit,
    input  logic [IDX_W-1:0]   commit_idx,
    output logic [ENTRIES-1:0] match_vec,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic               free_any,
    output logic [IDX_W-1:0]   free_idx
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];

    // Valid bits: flush wins, allocation clears, commit sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else begin
            if (alloc)  valid_q[alloc_idx]  <= 1'b0;
            if (commit) valid_q[commit_idx] <= 1'b1;
        end
    end

    // Tag storage written when an entry is allocated
    always_ff @(posedge clk) begin
        if (alloc) tag_q[alloc_idx] <= search_tag;
    end

    // Parallel compare, gated by the bank enable
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match_vec[i] = search_en && valid_q[i] && (tag_q[i] == search_tag);
    end

    // Encode the match and the lowest free entry
    always_comb begin
        hit      = |match_vec;
        free_any = ~&valid_q;
        hit_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx  = IDX_W'(i);
            if (!valid_q[i])  free_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/cc_data_ram.sv
// Data store with one write port and an asynchronous read port.
// Assumes: contents are undefined until a line is filled.
module cc_data_ram #(
    parameter int DW = 32,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [1 << AW];

    // Single write port
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cam_cache.sv
// Banked CAM-tag write-through cache.
// Address bits select one tag bank, which alone searches its entries.
// Read hits complete in the request cycle. Read misses fill a whole line
// in word order and then answer. Writes always go to memory.
// Assumes: the CPU holds cpu_req and its operands until cpu_ack, and the
// memory holds nothing between handshakes.
module cam_cache #(
    parameter int ADDR_W     = 28,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int BANKS      = 4,
    parameter int ENTRIES    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    import cam_cache_pkg::*;

    localparam int BYTE_BITS = $clog2(DATA_W / 8);
    localparam int WORD_BITS = $clog2(LINE_WORDS);
    localparam int BANK_BITS = $clog2(BANKS);
    localparam int IDX_BITS  = $clog2(ENTRIES);
    localparam int WORD_LSB  = BYTE_BITS;
    localparam int BANK_LSB  = WORD_LSB + WORD_BITS;
    localparam int TAG_LSB   = BANK_LSB + BANK_BITS;
    localparam int TAG_W     = ADDR_W - TAG_LSB;
    localparam int RAM_AW    = BANK_BITS + IDX_BITS + WORD_BITS;
    localparam logic [WORD_BITS-1:0] LAST_WORD = WORD_BITS'(LINE_WORDS - 1);

    cc_state_t             state_q;
    logic [ADDR_W-1:0]     lat_addr_q;
    logic [DATA_W-1:0]     lat_wdata_q;
    logic [WORD_BITS-1:0]  cnt_q;
    logic [IDX_BITS-1:0]   victim_q;
    logic [IDX_BITS-1:0]   lfsr_q;

    logic [ADDR_W-1:0]     srch_addr;
    logic [BANK_BITS-1:0]  bank_sel;
    logic [WORD_BITS-1:0]  word_sel;
    logic [TAG_W-1:0]      tag_sel;
    logic                  idle_rd;
    logic                  look_on;

    logic [BANKS-1:0]      b_hit;
    logic [BANKS-1:0]      b_free;
    logic [IDX_BITS-1:0]   b_hit_idx  [BANKS];
    logic [IDX_BITS-1:0]   b_free_idx [BANKS];
    logic [ENTRIES-1:0]    b_match    [BANKS];

    logic                  sel_hit;
    logic [IDX_BITS-1:0]   sel_hit_idx;
    logic [ENTRIES-1:0]    sel_match;
    logic                  any_hit;
    logic [IDX_BITS-1:0]   next_victim;
    logic                  miss_start;
    logic                  fill_done;

    logic                  ram_we;
    logic [RAM_AW-1:0]     ram_waddr;
    logic [DATA_W-1:0]     ram_wdata;
    logic [RAM_AW-1:0]     ram_raddr;

    // Lookup address: live request when idle, latched one otherwise
    always_comb begin
        srch_addr = (state_q == CC_IDLE) ? cpu_addr : lat_addr_q;
        bank_sel  = srch_addr[BANK_LSB +: BANK_BITS];
        word_sel  = srch_addr[WORD_LSB +: WORD_BITS];
        tag_sel   = srch_addr[TAG_LSB +: TAG_W];
        idle_rd   = (state_q == CC_IDLE) && cpu_req && !cpu_we;
        look_on   = ((state_q == CC_IDLE) && cpu_req) || (state_q == CC_WRITE);
    end

    cc_lfsr #(.W(IDX_BITS)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_q (lfsr_q)
    );

    // One tag bank per bank-select value; only the addressed one searches
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic is_sel;
        assign is_sel = (bank_sel == BANK_BITS'(b));

        cc_tag_bank #(
            .TAG_W   (TAG_W),
            .ENTRIES (ENTRIES),
            .IDX_W   (IDX_BITS)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .search_en  (is_sel && look_on),
            .search_tag (tag_sel),
            .alloc      (is_sel && miss_start),
            .alloc_idx  (next_victim),
            .commit     (is_sel && fill_done),
            .commit_idx (victim_q),
            .match_vec  (b_match[b]),
            .hit        (b_hit[b]),
            .hit_idx    (b_hit_idx[b]),
            .free_any   (b_free[b]),
            .free_idx   (b_free_idx[b])
        );
    end

    // Pick the addressed bank's results and the victim
    always_comb begin
        sel_hit     = b_hit[bank_sel];
        sel_hit_idx = b_hit_idx[bank_sel];
        sel_match   = b_match[bank_sel];
        any_hit     = |b_hit;
        next_victim = b_free[bank_sel] ? b_free_idx[bank_sel] : lfsr_q;
        miss_start  = idle_rd && !sel_hit;
        fill_done   = (state_q == CC_FILL) && mem_ack && (cnt_q == LAST_WORD);
    end

    // Control sequence: accept, write through, fill, respond
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= CC_IDLE;
            lat_addr_q  <= '0;
            lat_wdata_q <= '0;
            cnt_q       <= '0;
            victim_q    <= '0;
        end else begin
            case (state_q)
                CC_IDLE: begin
                    if (cpu_req) begin
                        lat_addr_q  <= cpu_addr;
                        lat_wdata_q <= cpu_wdata;
                        if (cpu_we) begin
                            state_q <= CC_WRITE;
                        end else if (!sel_hit) begin
                            victim_q <= next_victim;
                            cnt_q    <= '0;
                            state_q  <= CC_FILL;
                        end
                    end
                end
                CC_WRITE: begin
                    if (mem_ack) state_q <= CC_IDLE;
                end
                CC_FILL: begin
                    if (mem_ack) begin
                        if (cnt_q == LAST_WORD) state_q <= CC_RESP;
                        else                    cnt_q   <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= CC_IDLE;
            endcase
        end
    end

    // Data RAM port steering for fills, write hits and reads
    always_comb begin
        if (state_q == CC_FILL) begin
            ram_we    = mem_ack;
            ram_waddr = {bank_sel, victim_q, cnt_q};
            ram_wdata = mem_rdata;
        end else begin
            ram_we    = (state_q == CC_WRITE) && mem_ack && sel_hit;
            ram_waddr = {bank_sel, sel_hit_idx, word_sel};
            ram_wdata = lat_wdata_q;
        end
        ram_raddr = (state_q == CC_RESP) ? {bank_sel, victim_q, word_sel}
                                         : {bank_sel, sel_hit_idx, word_sel};
    end

    cc_data_ram #(.DW(DATA_W), .AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (cpu_rdata)
    );

    // Port outputs
    always_comb begin
        cpu_ack   = (idle_rd && sel_hit) || (state_q == CC_RESP)
                    || ((state_q == CC_WRITE) && mem_ack);
        mem_req   = (state_q == CC_WRITE) || (state_q == CC_FILL);
        mem_we    = (state_q == CC_WRITE);
        mem_wdata = lat_wdata_q;
        if (state_q == CC_FILL)
            mem_addr = {lat_addr_q[ADDR_W-1:BANK_LSB], cnt_q, {BYTE_BITS{1'b0}}};
        else
            mem_addr = lat_addr_q;
    end
endmodule

// File: rtl/cc_checker.sv
// Property checker for cam_cache, attached with bind.
// Assumes: it sees the top-level ports plus a few internal lookup signals.
module cc_checker #(
    parameter int ADDR_W  = 28,
    parameter int BANKS   = 4,
    parameter int ENTRIES = 64,
    parameter int IDX_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               cpu_ack,
    input logic               mem_req,
    input logic               mem_we,
    input logic               mem_ack,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [BANKS-1:0]   b_hit,
    input logic [ENTRIES-1:0] sel_match,
    input logic               any_hit,
    input logic [IDX_W-1:0]   lfsr_q
);
    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(b_hit)); // R3
    AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_match)); // R5
    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R7
    AST_LFSR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lfsr_q != $past(lfsr_q)); // R7
    AST_FILL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !cpu_ack); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr))); // R6
    AST_WRITE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |-> cpu_ack); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> !any_hit); // R9
endmodule

bind cam_cache cc_checker #(
    .ADDR_W  (ADDR_W),
    .BANKS   (BANKS),
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .cpu_ack   (cpu_ack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .b_hit     (b_hit),
    .sel_match (sel_match),
    .any_hit   (any_hit),
    .lfsr_q    (lfsr_q)
);

// File: tb/sim_cam_cache.sv
`timescale 1ns/1ps
module sim_cam_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [27:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ack;
    logic        mem_req;
    logic        mem_we;
    logic [27:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int fill_n = 0;
    int wr_n = 0;
    int stall_bad = 0;
    int last_fack = 0;
    int last_cack = 0;
    logic [27:0] fill_log [2048];
    logic [27:0] last_wa = '0;
    logic [31:0] last_wd = '0;
    logic [31:0] ovr [logic [25:0]];

    always #2.5 clk = ~clk;

    cam_cache u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [31:0] mem_val(input logic [27:0] a);
        if (ovr.exists(a[27:2])) return ovr[a[27:2]];
        return {4'hC, a[27:2], 2'b01};
    endfunction

    // Memory model: one-cycle acknowledge, logs every access
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                ovr[mem_addr[27:2]] = mem_wdata;
                last_wa = mem_addr;
                last_wd = mem_wdata;
                wr_n = wr_n + 1;
            end else begin
                mem_rdata <= mem_val(mem_addr);
                fill_log[fill_n % 2048] = mem_addr;
                fill_n = fill_n + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // Observation point well away from the edges
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (cpu_ack && mem_req && !mem_we) stall_bad++;
            if (mem_ack && !mem_we) last_fack = cyc;
            if (cpu_ack) last_cack = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [27:0] a, input logic [31:0] d,
                          input bit fl_last, output logic [31:0] rd, output int nf, output int nw);
        int f0 = fill_n;
        int w0 = wr_n;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        forever begin
            #1;
            if (fl_last && mem_ack && !mem_we && mem_addr[3:2] == 2'd3) flush = 1'b1;
            if (cpu_ack) break;
            @(negedge clk);
            flush = 1'b0;
        end
        rd = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
        nf = fill_n - f0;
        nw = wr_n - w0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
    endtask

    // {we, expect_hit, addr[27:0], wdata[31:0]}
    localparam int NV = 12;
    localparam logic [61:0] VEC [NV] = '{
        {1'b0, 1'b0, 28'h0000104, 32'h0},         // miss, bank 0
        {1'b0, 1'b1, 28'h0000108, 32'h0},         // hit same line
        {1'b0, 1'b1, 28'h0000107, 32'h0},         // byte bits ignored
        {1'b0, 1'b0, 28'h0000114, 32'h0},         // same tag, bank 1
        {1'b0, 1'b1, 28'h0000104, 32'h0},         // bank 0 line still there
        {1'b1, 1'b0, 28'h000010C, 32'hDEAD0001},  // write hit
        {1'b0, 1'b1, 28'h000010C, 32'h0},         // reads updated word
        {1'b1, 1'b0, 28'h0000200, 32'h12345678},  // write miss
        {1'b0, 1'b0, 28'h0000200, 32'h0},         // not allocated
        {1'b0, 1'b1, 28'h0000204, 32'h0},
        {1'b0, 1'b0, 28'hFFFFFF8, 32'h0},         // top tag, bank 3
        {1'b0, 1'b1, 28'hFFFFFF4, 32'h0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int nf;
        int nw;
        int hits;
        int misses;
        logic [27:0] a;

        repeat (3) @(negedge clk);
        chk(cpu_ack == 1'b0, "R10 cpu_ack in reset", 32'(cpu_ack), 0);
        chk(mem_req == 1'b0, "R10 mem_req in reset", 32'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(cpu_ack == 1'b0 && mem_req == 1'b0, "R10 idle after reset", 32'({cpu_ack, mem_req}), 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [61:0] v;
            v = VEC[i];
            cpu_op(v[61], v[59:32], v[31:0], 1'b0, rd, nf, nw);
            if (v[61]) begin
                chk(nw == 1 && last_wa == v[59:32] && last_wd == v[31:0],
                    $sformatf("R8 write through v%0d", i), last_wd, v[31:0]);
                chk(nf == 0, $sformatf("R8 no allocate v%0d", i), 32'(nf), 0);
            end else begin
                chk(rd == mem_val(v[59:32]), $sformatf("R1 R2 R5 data v%0d", i), rd, mem_val(v[59:32]));
                chk(nf == (v[60] ? 0 : 4), $sformatf("R2 R3 R4 fill count v%0d", i),
                    32'(nf), v[60] ? 32'd0 : 32'd4);
            end
        end

        // Fill order and response timing
        begin
            int s;
            s = fill_n;
            cpu_op(1'b0, 28'h0000348, 32'h0, 1'b0, rd, nf, nw);
            for (int k = 0; k < 4; k++)
                chk(fill_log[(s + k) % 2048] == 28'h0000340 + 28'(4 * k), "R4 fill order",
                    32'(fill_log[(s + k) % 2048]), 32'h340 + 32'(4 * k));
            chk(last_cack == last_fack + 1, "R5 ack after last fill word", 32'(last_cack), 32'(last_fack + 1));
            chk(rd == mem_val(28'h0000348), "R5 fill returns word", rd, mem_val(28'h0000348));
        end

        // Flush while idle
        cpu_op(1'b0, 28'h0000344, 32'h0, 1'b0, rd, nf, nw);
        chk(nf == 0, "R9 line resident before flush", 32'(nf), 0);
        pulse_flush();
        cpu_op(1'b0, 28'h0000344, 32'h0, 1'b0, rd, nf, nw);
        chk(nf == 4, "R9 miss after flush", 32'(nf), 4);

        // Flush on the last fill acknowledge
        cpu_op(1'b0, 28'h0000584, 32'h0, 1'b1, rd, nf, nw);
        chk(rd == mem_val(28'h0000584), "R9 R5 word returned despite flush", rd, mem_val(28'h0000584));
        cpu_op(1'b0, 28'h0000584, 32'h0, 1'b0, rd, nf, nw);
        chk(nf == 4, "R9 flush beats fill commit", 32'(nf), 4);

        // Bank capacity and replacement
        pulse_flush();
        for (int t = 1; t <= 64; t++) begin
            a = (28'(t) << 6) | 28'h20;
            cpu_op(1'b0, a, 32'h0, 1'b0, rd, nf, nw);
        end
        hits = 0;
        for (int t = 1; t <= 64; t++) begin
            a = (28'(t) << 6) | 28'h20;
            cpu_op(1'b0, a, 32'h0, 1'b0, rd, nf, nw);
            if (nf == 0) hits++;
        end
        chk(hits == 64, "R7 64 lines kept per bank", 32'(hits), 64);
        a = (28'(65) << 6) | 28'h24;
        cpu_op(1'b0, a, 32'h0, 1'b0, rd, nf, nw);
        chk(nf == 4, "R7 full bank miss", 32'(nf), 4);
        cpu_op(1'b0, a, 32'h0, 1'b0, rd, nf, nw);
        chk(nf == 0 && rd == mem_val(a), "R7 replacement line hits", rd, mem_val(a));
        misses = 0;
        for (int t = 1; t <= 64; t++) begin
            a = (28'(t) << 6) | 28'h20;
            cpu_op(1'b0, a, 32'h0, 1'b0, rd, nf, nw);
            if (nf != 0) misses++;
        end
        chk(misses >= 1 && misses <= 64, "R7 one entry was evicted", 32'(misses), 1);
        chk(stall_bad == 0, "R6 no ack during fill", 32'(stall_bad), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule